// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block receives asynchronous serial frames that carry nine data bits. It is meant for a multidrop bus, where the ninth bit marks a frame as an address byte (1) or a data byte (0). The block brings the receive line through a synchronizer and detects the start bit on a falling edge. It samples each bit in the middle of its period and rebuilds the frame in a shift register. When the stop bit arrives, it decides whether to keep the frame.

A frame is kept only while the receive flag is low. When the multiprocessor control input is high, a frame is also kept only if its ninth bit is 1. A node can therefore ignore all traffic until it sees an address byte. Host logic then compares that byte with its own addresses and drops the control input to take the data bytes that follow. A kept frame loads the byte register and the ninth-bit register and raises the receive flag. A dropped frame changes nothing. One interrupt line combines the receive flag with a transmit-done flag from outside, and an enable input gates it.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, `rxFlag`, `rxData`, `rxNinth` and `irq` are all 0.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit, each lasting `CLKS_PER_BIT` clocks, on a line that idles high. If a frame is kept, `rxData[0]` holds the first data bit, `rxData[7]` holds the eighth, `rxNinth` holds the ninth bit, and `rxFlag` becomes 1.
- R3: A frame whose stop bit arrives while `rxFlag` is 1 is dropped. `rxData`, `rxNinth` and `rxFlag` keep their values.
- R4: While `mpEnable` is 1, a frame with ninth bit 0 is dropped and leaves all three outputs unchanged, and a frame with ninth bit 1 is kept. While `mpEnable` is 0, the ninth bit has no effect on whether a frame is kept.
- R5: A one-cycle high on `rxClear` drops `rxFlag` to 0. If a frame is kept in the same cycle as a clear, the flag is set.
- R6: `irq` is 1 exactly when `irqEnable` is 1 and at least one of `rxFlag` and `txDone` is 1.
- R7: If the line returns high before the middle of the start bit, the low pulse is treated as a glitch. No frame is produced, and a correct frame that follows is received normally.
- R8: The keep-or-drop decision happens in the middle of the stop bit. The receiver then waits for a new start edge, so frames sent back to back with no idle time between them are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial receive line, idles high |
| mpEnable | input | 1 | When 1, only frames with ninth bit 1 are kept |
| rxClear | input | 1 | One-cycle strobe that clears the receive flag |
| txDone | input | 1 | External transmit-done flag, feeds the interrupt |
| irqEnable | input | 1 | Interrupt gate |
| rxData | output | 8 | Data byte of the last kept frame |
| rxNinth | output | 1 | Ninth bit of the last kept frame |
| rxFlag | output | 1 | Receive flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that the byte and ninth-bit registers do not change while the flag is high. They also check that the flag rises only on a stop-bit decision, and only with ninth bit 1 when the multiprocessor control is on. Further cycle checks cover clear without a decision, interrupt gating, and the return to idle after each decision. Only the bench scenarios can show correct bit order and sampling position, glitch rejection, and the set-over-clear priority. The bench sends every one of the 512 nine-bit frame values back to back and compares the outputs with values built from the frame it sent.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rxState_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic shift;   // take bitVal into the frame shift register
    logic bitVal;  // sampled line level
    logic decide;  // mid-stop-bit acceptance point
  } rxStrobe_t;
endpackage

// File: rtl/mdrop_rx_ctrl.sv
module mdrop_rx_ctrl
  import mdrop_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int FRAME_BITS   = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxLine,
  output rxStrobe_t strobe,
  output logic      busy
);
  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDX_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam int HALF  = CLKS_PER_BIT / 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic rxSync;
  logic rxPrev;
  rxState_e state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic midStart;
  logic bitEnd;

  assign rxSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      rxPrev    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
      rxPrev    <= rxSync;
    end
  end

  always_comb begin
    midStart      = (state == ST_START) && (cnt == CNT_W'(HALF - 1));
    bitEnd        = (cnt == CNT_W'(CLKS_PER_BIT - 1));
    strobe.shift  = (state == ST_BITS) && bitEnd;
    strobe.bitVal = rxSync;
    strobe.decide = (state == ST_STOP) && bitEnd;
    busy          = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (rxPrev && !rxSync) state <= ST_START;
        end
        ST_START: begin
          if (midStart) begin
            cnt   <= '0;
            state <= rxSync ? ST_IDLE : ST_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (bitEnd) begin
            cnt <= '0;
            if (idx == IDX_W'(FRAME_BITS - 1)) state <= ST_STOP;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_rx_data.sv
module mdrop_rx_data
  import mdrop_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              mpEnable,
  input  logic              rxClear,
  input  logic              txDone,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxFlag,
  output logic              irq
);
  logic [DATA_W:0] shiftReg;
  logic acceptNow;

  assign acceptNow = strobe.decide && !rxFlag && (!mpEnable || shiftReg[DATA_W]);
  assign irq       = irqEnable && (rxFlag || txDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {strobe.bitVal, shiftReg[DATA_W:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxNinth <= 1'b0;
      rxFlag  <= 1'b0;
    end else begin
      if (acceptNow) begin
        rxData  <= shiftReg[DATA_W-1:0];
        rxNinth <= shiftReg[DATA_W];
        rxFlag  <= 1'b1;
      end else if (rxClear) begin
        rxFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              mpEnable,
  input  logic              rxClear,
  input  logic              txDone,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              rxFlag,
  output logic              irq
);
  localparam int FRAME_BITS = DATA_W + 1;

  rxStrobe_t rxStrobe;
  logic rxBusy;

  mdrop_rx_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .FRAME_BITS  (FRAME_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .rxLine(rxLine),
    .strobe(rxStrobe),
    .busy  (rxBusy)
  );

  mdrop_rx_data #(
    .DATA_W(DATA_W)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (rxStrobe),
    .mpEnable (mpEnable),
    .rxClear  (rxClear),
    .txDone   (txDone),
    .irqEnable(irqEnable),
    .rxData   (rxData),
    .rxNinth  (rxNinth),
    .rxFlag   (rxFlag),
    .irq      (irq)
  );
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              mpEnable,
  input logic              rxClear,
  input logic              txDone,
  input logic              irqEnable,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth,
  input logic              rxFlag,
  input logic              irq,
  input logic              decide,
  input logic              busy
);
  // R3: a full receiver keeps its byte and ninth bit
  assert_full_holds_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag |=> ($stable(rxData) && $stable(rxNinth)));

  // R2: the flag only rises from a stop-bit decision
  assert_set_from_decide_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(decide));

  // R4: with multiprocessor filtering on, only address frames raise the flag
  assert_addr_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(mpEnable)) |-> rxNinth);

  // R5: a clear without a decision empties the flag
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxClear && !decide) |=> !rxFlag);

  // R6: interrupt gating
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq);
  assert_irq_tx_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && txDone) |-> irq);

  // R8: back to idle after every decision
  assert_idle_after_decide_R8: assert property (@(posedge clk) disable iff (!rstN)
    decide |=> !busy);
endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .mpEnable (mpEnable),
  .rxClear  (rxClear),
  .txDone   (txDone),
  .irqEnable(irqEnable),
  .rxData   (rxData),
  .rxNinth  (rxNinth),
  .rxFlag   (rxFlag),
  .irq      (irq),
  .decide   (rxStrobe.decide),
  .busy     (rxBusy)
);

// File: tb/mdrop_rx_tb.sv
`timescale 1ns/1ps
module mdrop_rx_tb_top;
  localparam int CPB = 16;

  logic clk = 1'b0;
  logic rstN;
  logic rxLine, mpEnable, rxClear, txDone, irqEnable;
  logic [7:0] rxData;
  logic rxNinth, rxFlag, irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;
  bit sawFlag = 1'b0;
  logic [7:0] expData;
  logic expNinth;

  always #5 clk = ~clk;

  mdrop_rx #(.CLKS_PER_BIT(CPB), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .mpEnable(mpEnable),
    .rxClear(rxClear), .txDone(txDone), .irqEnable(irqEnable),
    .rxData(rxData), .rxNinth(rxNinth), .rxFlag(rxFlag), .irq(irq)
  );

  always @(negedge clk) if (rxFlag) sawFlag = 1'b1;

  task automatic checkVal(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [8:0] w);
    rxLine = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rxLine = w[i];
      repeat (CPB) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (CPB - 1) @(negedge clk);
  endtask

  task automatic pulseClear();
    rxClear = 1'b1;
    @(negedge clk);
    rxClear = 1'b0;
  endtask

  task automatic checkOutputs(input string req, input int flag);
    checkVal({req, " data"}, int'(rxData), int'(expData));
    checkVal({req, " ninth"}, int'(rxNinth), int'(expNinth));
    checkVal({req, " flag"}, int'(rxFlag), flag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rxLine = 1'b1; mpEnable = 1'b0; rxClear = 1'b0;
    txDone = 1'b0; irqEnable = 1'b0;
    expData = 8'h00; expNinth = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    // R1 reset state
    checkOutputs("R1", 0);
    checkVal("R1 irq", int'(irq), 0);

    // R6 interrupt with flag low
    irqEnable = 1'b1; @(negedge clk);
    checkVal("R6 en no source", int'(irq), 0);
    txDone = 1'b1; @(negedge clk);
    checkVal("R6 en tx", int'(irq), 1);
    irqEnable = 1'b0; @(negedge clk);
    checkVal("R6 gated tx", int'(irq), 0);
    txDone = 1'b0;

    // R2 R8: all 512 frames back to back, filter off
    for (int w = 0; w < 512; w++) begin
      sendFrame(9'(w));
      expData = 8'(w); expNinth = w[8];
      checkOutputs("R2 R8 sweep", 1);
      if (w == 5) begin
        irqEnable = 1'b1; #1;
        checkVal("R6 rx flag", int'(irq), 1);
        irqEnable = 1'b0;
      end
      pulseClear();
      checkVal("R5 clear", int'(rxFlag), 0);
    end

    // R4: filter on, data frames dropped, address frames kept
    mpEnable = 1'b1;
    for (int v = 0; v < 64; v++) begin
      for (int n = 0; n < 2; n++) begin
        logic [7:0] d;
        d = 8'((v * 37 + 11) & 255);
        sendFrame({n[0], d});
        if (n == 1) begin
          expData = d; expNinth = 1'b1;
          checkOutputs("R4 address kept", 1);
          pulseClear();
        end else begin
          checkOutputs("R4 data dropped", 0);
          @(negedge clk);
        end
      end
    end
    mpEnable = 1'b0;

    // R3: second frame while flag still high is dropped
    sendFrame(9'h0A5);
    expData = 8'hA5; expNinth = 1'b0;
    checkOutputs("R3 first", 1);
    @(negedge clk);
    sendFrame(9'h15A);
    checkOutputs("R3 overrun dropped", 1);
    irqEnable = 1'b0; #1;
    checkVal("R6 gated rx", int'(irq), 0);
    pulseClear();

    // R5: clear held through the decision, set wins
    rxClear = 1'b1;
    @(negedge clk);
    sawFlag = 1'b0;
    sendFrame(9'h13C);
    expData = 8'h3C; expNinth = 1'b1;
    checkVal("R5 set beats clear", int'(sawFlag), 1);
    checkOutputs("R5 after clear", 0);
    rxClear = 1'b0;
    @(negedge clk);

    // R7: short low pulse is ignored
    rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    checkOutputs("R7 glitch", 0);
    sendFrame(9'h066);
    expData = 8'h66; expNinth = 1'b0;
    checkOutputs("R7 frame after glitch", 1);
    pulseClear();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule